// File: doc/BRIEF.md
# Serial-Controlled Protected Octal Switch Controller

This block is the digital core of an eight-channel low-side switch. A host shifts one on/off bit per channel into a shift register through a serial clock and data pair. A strobe then copies the shifted word into an output buffer that commands the channels. The last shift stage drives a serial output, so several such devices, or devices of other widths, can share one serial line and one strobe.

Protection runs alongside the command path:
- An active-low enable turns every channel off without disturbing the buffer.
- Each channel has its own over-current latch. A latch turns off only its own channel and is released by the next strobe.
- An active-low fault flag reports that at least one latch is set.
- A temperature code with hysteresis forces a global shutdown. The fault flag does not report this shutdown.

All serial and control pins are asynchronous to the system clock. They pass through two-flop synchronizers, and edges are detected in the system clock domain. The over-current detect bits and the temperature code are taken as already synchronous to the system clock.

Top module: `octal_switch_ctrl`

## Requirements
- R1: Each rising edge of the serial clock shifts the serial data bit into stage 0 of the shift register, and every stage moves up by one. After eight edges, the first bit shifted in sits in bit 7, which commands channel 7.
- R2: The serial output always equals bit 7 of the shift register. A word shifted in therefore leaves the serial output, most significant bit first, while the next eight bits are shifted in.
- R3: While the strobe is high, the output buffer follows the shift register. While the strobe is low, the buffer holds its value, even while new bits are being shifted.
- R4: A buffer bit of 1 turns the matching drive output on, and a buffer bit of 0 turns it off.
- R5: While the enable input is high, all eight drive outputs are 0. When the enable input returns low, the drive outputs again follow the buffer, which was kept unchanged.
- R6: An over-current detect on a channel that is currently driven sets that channel's latch. A set latch holds the channel off, and keeps holding it after the detect goes away. All other channels continue unchanged.
- R7: The rising edge of the strobe clears the over-current latches. If the detect of a channel is still asserted while that channel is commanded on, setting the latch takes priority and the channel stays latched off.
- R8: The fault output is 0 exactly while at least one over-current latch is set. Thermal shutdown alone leaves the fault output at 1.
- R9: A temperature code at or above the trip threshold (default 155) forces all drive outputs to 0. Shutdown continues until the code falls below the release threshold (default 145).
- R10: Reset clears the shift register, the buffer, the over-current latches and the thermal state. During reset and right after it, the drive outputs are 0, the serial output is 0 and the fault output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| sckIn | input | 1 | Serial clock, asynchronous |
| siIn | input | 1 | Serial data in, asynchronous |
| strIn | input | 1 | Strobe, high for transparent load, asynchronous |
| enN | input | 1 | Active-low global output enable, asynchronous |
| ocDet | input | CH | Per-channel over-current detect, synchronous |
| tempCode | input | TEMP_W | Unsigned die temperature code in degrees |
| drive | output | CH | Per-channel drive enable |
| soOut | output | 1 | Serial data out for cascading |
| fltN | output | 1 | Active-low over-current fault flag |

## Verification
Two events can land in the same cycle: a channel's over-current detect, and the strobe edge that clears the latches. The bench provokes the collision by holding a detect asserted on a channel that is driven while it strobes the same word again. It expects the channel to stay latched off and the fault output to stay low. It then drops the detect, strobes again, and expects the channel to return and the flag to go high. Random sequences of shifting, strobing, enable changes, temperature changes around both thresholds and fault injections are compared against a bench model of the buffer, the latches and the hysteresis.

// File: rtl/octal_switch_pkg.sv
package octal_switch_pkg;
  // Strobes and levels handed from the control side to the datapath.
  typedef struct packed {
    logic shiftPulse;   // one cycle per detected serial clock rise
    logic serialBit;    // synchronized serial data
    logic loadLevel;    // synchronized strobe level (transparent load)
    logic loadRise;     // one cycle on strobe rising edge
    logic outEnable;    // synchronized, active-high enable
    logic thermalHold;  // global over-temperature shutdown
  } ctrlStrobes_t;
endpackage

// File: rtl/osc_sync_bit.sv
module osc_sync_bit #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/osc_control.sv
module osc_control
  import octal_switch_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int TRIP_C      = 155,
  parameter int RELEASE_C   = 145,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              siIn,
  input  logic              strIn,
  input  logic              enN,
  input  logic [TEMP_W-1:0] tempCode,
  output ctrlStrobes_t      ctrl
);
  localparam int N_SYNC = 4;
  localparam logic [N_SYNC-1:0] SYNC_RST = 4'b0001;  // enable pin resets inactive
  localparam logic [TEMP_W-1:0] TRIP_T = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] REL_T  = TEMP_W'(RELEASE_C);

  logic [N_SYNC-1:0] rawIn, syncOut;
  assign rawIn = {sckIn, siIn, strIn, enN};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    osc_sync_bit #(.STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST[g])) u_sync (
      .clk (clk), .rstN(rstN), .din(rawIn[g]), .dout(syncOut[g])
    );
  end

  logic sckSync, siSync, strSync, enNSync;
  assign {sckSync, siSync, strSync, enNSync} = syncOut;

  logic sckPrev, strPrev, hotReg;
  logic [TEMP_W-1:0] tempReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      strPrev <= 1'b0;
      tempReg <= '0;
      hotReg  <= 1'b0;
    end else begin
      sckPrev <= sckSync;
      strPrev <= strSync;
      tempReg <= tempCode;
      if (tempReg >= TRIP_T)     hotReg <= 1'b1;
      else if (tempReg < REL_T)  hotReg <= 1'b0;
    end
  end

  always_comb begin
    ctrl.shiftPulse  = sckSync & ~sckPrev;
    ctrl.serialBit   = siSync;
    ctrl.loadLevel   = strSync;
    ctrl.loadRise    = strSync & ~strPrev;
    ctrl.outEnable   = ~enNSync;
    ctrl.thermalHold = hotReg;
  end

  // R9: a code at or above the trip point enters shutdown next cycle
  p_trip_enter_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tempReg >= TRIP_T) |=> hotReg);
  // R9: inside the hysteresis band the shutdown state is kept
  p_band_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tempReg >= REL_T && tempReg < TRIP_T) |=> (hotReg == $past(hotReg)));
  // R1: one shift pulse per serial clock rise, never two in a row
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftPulse |=> !ctrl.shiftPulse);
endmodule

// File: rtl/osc_datapath.sv
module osc_datapath
  import octal_switch_pkg::*;
#(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  ctrl,
  input  logic [CH-1:0] ocDet,
  output logic [CH-1:0] drive,
  output logic          soOut,
  output logic          fltN
);
  logic [CH-1:0] shiftReg, bufReg, ocLatch, channelLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bufReg   <= '0;
    end else begin
      if (ctrl.shiftPulse) shiftReg <= {shiftReg[CH-2:0], ctrl.serialBit};
      if (ctrl.loadLevel)  bufReg   <= shiftReg;
    end
  end

  assign channelLive = bufReg & {CH{ctrl.outEnable & ~ctrl.thermalHold}};

  for (genvar i = 0; i < CH; i++) begin : g_oc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           ocLatch[i] <= 1'b0;
      else if (ocDet[i] && channelLive[i]) ocLatch[i] <= 1'b1;  // set wins
      else if (ctrl.loadRise)              ocLatch[i] <= 1'b0;
    end
  end

  assign drive = channelLive & ~ocLatch;
  assign soOut = shiftReg[CH-1];
  assign fltN  = ~(|ocLatch);

  // R1: the synchronized serial bit lands in stage 0
  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftPulse |=> (shiftReg[0] == $past(ctrl.serialBit)));
  // R2: the serial output carries the old next-to-last stage after a shift
  p_so_chain_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftPulse |=> (soOut == $past(shiftReg[CH-2])));
  // R3: the buffer holds while the strobe is low
  p_buf_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadLevel |=> $stable(bufReg));
  // R6: a latch never clears without a strobe edge
  p_latch_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadRise |=> ((ocLatch & $past(ocLatch)) == $past(ocLatch)));
  // R7: a strobe edge with no detect pending clears every latch
  p_latch_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadRise && ocDet == '0) |=> (ocLatch == '0));
endmodule

// File: rtl/octal_switch_ctrl.sv
module octal_switch_ctrl
  import octal_switch_pkg::*;
#(
  parameter int CH        = 8,
  parameter int TEMP_W    = 8,
  parameter int TRIP_C    = 155,
  parameter int RELEASE_C = 145
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              siIn,
  input  logic              strIn,
  input  logic              enN,
  input  logic [CH-1:0]     ocDet,
  input  logic [TEMP_W-1:0] tempCode,
  output logic [CH-1:0]     drive,
  output logic              soOut,
  output logic              fltN
);
  ctrlStrobes_t ctrl;

  osc_control #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .RELEASE_C(RELEASE_C),
                .SYNC_STAGES(2)) u_control (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .siIn(siIn), .strIn(strIn),
    .enN(enN), .tempCode(tempCode), .ctrl(ctrl)
  );

  osc_datapath #(.CH(CH)) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .ocDet(ocDet),
    .drive(drive), .soOut(soOut), .fltN(fltN)
  );

  // R5: no channel is driven while the enable is inactive
  p_enable_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.outEnable |-> (drive == '0));
  // R9: no channel is driven during thermal shutdown
  p_thermal_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.thermalHold |-> (drive == '0));
  // R8: thermal shutdown entry alone does not pull the fault flag low
  p_flag_not_thermal_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctrl.thermalHold) && $past(fltN)) |-> fltN);
endmodule

// File: tb/octal_switch_ctrl_bench.sv
module octal_switch_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, siIn = 1'b0, strIn = 1'b0, enN = 1'b1;
  logic [7:0] ocDet = '0;
  logic [7:0] tempCode = 8'd25;
  logic [7:0] drive;
  logic soOut, fltN;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] mShift = '0, mBuf = '0, mLatch = '0;
  bit mEn = 0, mHot = 0;

  always #5 clk = ~clk;

  octal_switch_ctrl u_octal_switch_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .siIn(siIn), .strIn(strIn),
    .enN(enN), .ocDet(ocDet), .tempCode(tempCode),
    .drive(drive), .soOut(soOut), .fltN(fltN)
  );

  function automatic logic [7:0] onMask();
    return (mEn && !mHot) ? mBuf : 8'h00;
  endfunction

  function automatic logic [7:0] expDrive();
    return onMask() & ~mLatch;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkAll(string req);
    chk({req, " drive"}, 32'(drive), 32'(expDrive()));
    chk({req, " fault"}, 32'(fltN), 32'(mLatch == 8'h00));
    chk({req, " serial out"}, 32'(soOut), 32'(mShift[7]));
  endtask

  task automatic shiftBit(logic b);
    siIn = b; tick(2);
    sckIn = 1'b1; tick(3);
    sckIn = 1'b0; tick(3);
    mShift = {mShift[6:0], b};
  endtask

  task automatic shiftWord(logic [7:0] w);
    for (int i = 7; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic strobe();
    strIn = 1'b1; tick(4);
    strIn = 1'b0; tick(4);
    mBuf = mShift;
    mLatch = ocDet & onMask();
  endtask

  task automatic setEn(logic v);
    enN = v; tick(4);
    mEn = !v;
  endtask

  task automatic setTemp(logic [7:0] t);
    tempCode = t; tick(4);
    if (t >= 8'd155) mHot = 1;
    else if (t < 8'd145) mHot = 0;
  endtask

  task automatic injectOc(logic [7:0] mask);
    mLatch = mLatch | (mask & onMask());
    ocDet = mask; tick(3);
    ocDet = '0; tick(3);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    // R10: outputs during reset
    chk("R10 drive in reset", 32'(drive), 0);
    chk("R10 fault in reset", 32'(fltN), 1);
    chk("R10 serial out in reset", 32'(soOut), 0);
    rstN = 1'b1; tick(3);
    chkAll("R10 after reset");

    setEn(1'b0);
    // R1 R4: a word lands with its first bit on channel 7
    shiftWord(8'hA5); strobe();
    chkAll("R1 R4 load A5");
    chk("R4 pattern A5", 32'(drive), 32'h A5);
    // R3: shifting without strobe leaves the outputs alone
    shiftWord(8'h3C);
    chkAll("R3 hold while strobe low");
    // R2: the previous word leaves the serial output MSB first
    for (int i = 7; i >= 0; i--) begin
      shiftBit(1'(i & 1));
      chk("R2 cascade bit", 32'(soOut), 32'(mShift[7]));
    end
    strobe(); chkAll("R3 R4 load after cascade");
    // R5
    shiftWord(8'hFF); strobe();
    setEn(1'b1); chkAll("R5 disabled");
    chk("R5 all off", 32'(drive), 0);
    setEn(1'b0); chkAll("R5 buffer restored");
    // R6: isolated latch-off
    injectOc(8'h04);
    chkAll("R6 one channel latched");
    chk("R6 others on", 32'(drive), 32'hFB);
    chk("R8 flag low", 32'(fltN), 0);
    // R7: detect held across strobe keeps the latch
    ocDet = 8'h04; tick(2);
    strobe();
    chkAll("R7 set wins over strobe");
    chk("R7 latched channel stays off", 32'(drive), 32'hFB);
    ocDet = '0; tick(2);
    strobe();
    chkAll("R7 released by strobe");
    chk("R7 all back on", 32'(drive), 32'hFF);
    // R8 R9: thermal shutdown with hysteresis, flag untouched
    setTemp(8'd160);
    chkAll("R9 tripped");
    chk("R8 flag high in shutdown", 32'(fltN), 1);
    setTemp(8'd150); chkAll("R9 held in band");
    setTemp(8'd145); chkAll("R9 held at release");
    setTemp(8'd144); chkAll("R9 released");
    setTemp(8'd155); chkAll("R9 trip at threshold");
    setTemp(8'd30);  chkAll("R9 cool again");

    // random mix
    for (int k = 0; k < 80; k++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: begin shiftWord(8'($urandom)); strobe(); chkAll("R1 R3 R4 random load"); end
        1: begin setEn(1'($urandom)); chkAll("R5 random enable"); end
        2: begin setTemp(8'(130 + $urandom % 40)); chkAll("R9 random temperature"); end
        3: begin injectOc(8'($urandom)); chkAll("R6 R8 random fault"); end
        default: begin strobe(); chkAll("R7 random strobe"); end
      endcase
    end

    // R10: reset mid-operation
    rstN = 1'b0; tick(2);
    mShift = '0; mBuf = '0; mLatch = '0; mHot = 0;
    chkAll("R10 reset again");
    rstN = 1'b1; tick(3);
    chkAll("R10 released again");

    done = 1;
    report();
  end
endmodule